// File: doc/BRIEF.md
# Dual-Mode Double-Buffered Converter Front End

This block is the digital front end of a 14-bit digital-to-analog converter. A host delivers a data word in one of two ways. In parallel mode it drives a word onto a 14-bit data bus and strobes an active-low select line together with an active-low write line. In serial mode it uses three wires: a frame sync, a serial clock and serial data. A static strap picks the mode. In serial mode the write line becomes the frame sync, and four of the upper data pins take on the serial clock, serial data, bit-order and justification roles.

Each received word lands in an input latch. A separate active-low load strobe, which has no timing tie to the write path, copies the input latch into the output latch that drives the converter code. That copy also raises a one-cycle update pulse. The host can therefore stage the next sample while the converter holds the current one. Every external strobe and data pin is asynchronous. Each passes through a synchronizer on a fast system clock before edge detection.

Top module: `dac_dual_front`

## Requirements
- R1: While reset is active, and right after it, both the input latch and the output latch hold the mid-scale code 0x2000, and `dac_update_o` is 0.
- R2: In parallel mode (`ser_strap_i`=0), the input latch takes `data_i` only when the period in which `sel_n_i` and `wr_n_i` are both low ends. The value taken is the bus value at that moment. A write pulse while select is high, or a select pulse while write is high, leaves the input latch unchanged.
- R3: A falling edge on `load_n_i` copies the input latch into `dac_code_o`. No other event changes `dac_code_o`. In particular, a completed write or serial frame does not change it.
- R4: `dac_update_o` is high for exactly one cycle for each falling edge of `load_n_i`, including when the copied value equals the old one.
- R5: In serial mode (`ser_strap_i`=1), `sel_n_i` and the parallel meaning of `data_i` are ignored. A write-line pulse with no serial clock edges leaves the input latch unchanged.
- R6: In serial mode, `wr_n_i` is an active-low frame sync. Serial data on `data_i[13]` is sampled on each falling edge of the serial clock on `data_i[12]` while the frame sync is low. Clock edges while the frame sync is high are ignored.
- R7: The bit-order pin `data_i[11]` set to 1 means the first valid serial bit is the MSB of the word. Set to 0, it means the first valid bit is the LSB.
- R8: Only the first 16 bits of a frame are kept. With the justify pin `data_i[10]` at 1, the word is the last 14 kept bits. At 0, it is the first 14 kept bits.
- R9: The input latch is written from a serial frame when the frame sync rises, and only if at least 14 bits were kept. A shorter frame leaves the input latch unchanged.
- R10: Take the first rising clock edge that samples `load_n_i` low as edge 1. `dac_code_o` shows the new value, and `dac_update_o` is high, after edge 3 and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than any strobe |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ser_strap_i | input | 1 | Static mode strap: 1 selects serial mode |
| sel_n_i | input | 1 | Active-low select, used in parallel mode only |
| wr_n_i | input | 1 | Active-low write (parallel) or frame sync (serial) |
| data_i | input | 14 | Parallel word. In serial mode: [13] data, [12] clock, [11] bit order, [10] justify |
| load_n_i | input | 1 | Active-low load strobe, acts on its falling edge |
| dac_code_o | output | 14 | Output latch, the converter code |
| dac_update_o | output | 1 | One-cycle pulse when the output latch is loaded |

## Verification
The hardest cases to reach are the serial frames whose length does not equal the word width. A frame of 15 or 18 bits must be cut according to the justify pin. A frame of 12 bits must be dropped entirely. Serial clock edges that arrive while the frame sync is high must leave no trace. The stimulus builds each frame from a known word, adding junk bits set to 1 before or after the data, then truncates it to the chosen length. After every frame a load pulse moves the input latch to the output, so the effect of the frame is visible at the ports. A behavioural model with a queue of received bits also predicts both outputs on every cycle.

// File: rtl/dac_dual_front_pkg.sv
package dac_dual_front_pkg;

  // Strobe set carried alongside the data through the synchronizer.
  typedef struct packed {
    logic load_n;
    logic wr_n;
    logic sel_n;
  } strobe_t;

  localparam int unsigned STROBE_W = $bits(strobe_t);

  // Bipolar zero: only the top bit set.
  function automatic logic [31:0] mid_code(input int unsigned width);
    return 32'd1 << (width - 1);
  endfunction

endpackage

// File: rtl/dac_dual_front_sync.sv
module dac_dual_front_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= {STAGES{RST_VAL}};
    else         stg_q <= {stg_q[STAGES-2:0], d_i};
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/dac_dual_front_edge.sv
module dac_dual_front_edge #(
  parameter int unsigned W        = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cur_i,
  output logic [W-1:0] prv_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prv_o <= RST_VAL;
    else         prv_o <= cur_i;
  end

endmodule

// File: rtl/dac_dual_front_par.sv
module dac_dual_front_par #(
  parameter int unsigned WORD_W = 14
) (
  input  logic              en_i,
  input  logic              sel_n_cur_i,
  input  logic              wr_n_cur_i,
  input  logic              sel_n_prv_i,
  input  logic              wr_n_prv_i,
  input  logic [WORD_W-1:0] data_i,
  output logic              vld_o,
  output logic [WORD_W-1:0] word_o
);

  logic act_cur, act_prv;

  // R2: write window is select AND write both low; capture on its trailing edge
  assign act_cur = ~sel_n_cur_i & ~wr_n_cur_i;
  assign act_prv = ~sel_n_prv_i & ~wr_n_prv_i;
  assign vld_o   = en_i & act_prv & ~act_cur;
  assign word_o  = data_i;

endmodule

// File: rtl/dac_dual_front_ser.sv
module dac_dual_front_ser #(
  parameter int unsigned WORD_W    = 14,
  parameter int unsigned FRAME_LEN = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              fs_n_cur_i,
  input  logic              fs_n_prv_i,
  input  logic              sclk_cur_i,
  input  logic              sclk_prv_i,
  input  logic              sdata_i,
  input  logic              msb_first_i,
  input  logic              right_just_i,
  output logic              vld_o,
  output logic [WORD_W-1:0] word_o
);

  localparam int unsigned CNT_W = $clog2(FRAME_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_WORD  = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_FRAME = CNT_W'(FRAME_LEN);

  logic [FRAME_LEN-1:0] shift_q;
  logic [CNT_W-1:0]     cnt_q;
  logic                 fs_fall, fs_rise, bit_stb;
  logic [FRAME_LEN-1:0] left_al;
  logic [WORD_W-1:0]    aligned, reversed;

  assign fs_fall = fs_n_prv_i & ~fs_n_cur_i;
  assign fs_rise = ~fs_n_prv_i & fs_n_cur_i;
  // R6: bits only on serial clock fall inside an open frame
  assign bit_stb = ~fs_n_cur_i & ~fs_fall & sclk_prv_i & ~sclk_cur_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= '0;
      cnt_q   <= '0;
    end else if (!en_i || fs_fall) begin
      shift_q <= '0;
      cnt_q   <= '0;
    end else if (bit_stb && (cnt_q < CNT_FRAME)) begin
      // R8: bits past the frame length are dropped
      shift_q <= {shift_q[FRAME_LEN-2:0], sdata_i};
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  // Oldest kept bit sits at shift_q[cnt_q-1]; newest at shift_q[0].
  assign left_al = shift_q >> (cnt_q - CNT_WORD);
  assign aligned = right_just_i ? shift_q[WORD_W-1:0] : left_al[WORD_W-1:0];

  for (genvar i = 0; i < WORD_W; i++) begin : g_rev
    assign reversed[i] = aligned[WORD_W-1-i];
  end

  // R7: first-arriving bit is MSB when msb_first_i, else LSB
  assign word_o = msb_first_i ? aligned : reversed;
  // R9: commit only full words at frame close
  assign vld_o  = en_i & fs_rise & (cnt_q >= CNT_WORD);

endmodule

// File: rtl/dac_dual_front.sv
module dac_dual_front
  import dac_dual_front_pkg::*;
#(
  parameter int unsigned WORD_W      = 14,
  parameter int unsigned FRAME_LEN   = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ser_strap_i,
  input  logic              sel_n_i,
  input  logic              wr_n_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic              load_n_i,
  output logic [WORD_W-1:0] dac_code_o,
  output logic              dac_update_o
);

  localparam int unsigned VEC_W    = WORD_W + STROBE_W;
  localparam int unsigned PIN_SDAT = WORD_W - 1;
  localparam int unsigned PIN_SCLK = WORD_W - 2;
  localparam int unsigned PIN_ORD  = WORD_W - 3;
  localparam int unsigned PIN_JUST = WORD_W - 4;
  localparam logic [WORD_W-1:0] MID = WORD_W'(mid_code(WORD_W));
  localparam strobe_t STB_IDLE = '{load_n: 1'b1, wr_n: 1'b1, sel_n: 1'b1};
  localparam logic [VEC_W-1:0] VEC_IDLE = {STB_IDLE, {WORD_W{1'b0}}};

  logic [VEC_W-1:0]  raw_vec, cur_vec, prv_vec;
  strobe_t           stb_cur, stb_prv;
  logic [WORD_W-1:0] dat_cur, dat_prv;

  logic              par_vld, ser_vld;
  logic [WORD_W-1:0] par_word, ser_word;
  logic              load_fall;

  logic [WORD_W-1:0] in_lat;
  logic [WORD_W-1:0] dac_q;
  logic              upd_q;

  assign raw_vec = {load_n_i, wr_n_i, sel_n_i, data_i};

  dac_dual_front_sync #(
    .W       (VEC_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (VEC_IDLE)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (raw_vec),
    .q_o    (cur_vec)
  );

  dac_dual_front_edge #(
    .W       (VEC_W),
    .RST_VAL (VEC_IDLE)
  ) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cur_i  (cur_vec),
    .prv_o  (prv_vec)
  );

  assign stb_cur = strobe_t'(cur_vec[VEC_W-1:WORD_W]);
  assign stb_prv = strobe_t'(prv_vec[VEC_W-1:WORD_W]);
  assign dat_cur = cur_vec[WORD_W-1:0];
  assign dat_prv = prv_vec[WORD_W-1:0];

  // R2/R5: strap steers the shared pins to exactly one receiver
  dac_dual_front_par #(
    .WORD_W (WORD_W)
  ) u_par (
    .en_i        (~ser_strap_i),
    .sel_n_cur_i (stb_cur.sel_n),
    .wr_n_cur_i  (stb_cur.wr_n),
    .sel_n_prv_i (stb_prv.sel_n),
    .wr_n_prv_i  (stb_prv.wr_n),
    .data_i      (dat_cur),
    .vld_o       (par_vld),
    .word_o      (par_word)
  );

  dac_dual_front_ser #(
    .WORD_W    (WORD_W),
    .FRAME_LEN (FRAME_LEN)
  ) u_ser (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (ser_strap_i),
    .fs_n_cur_i   (stb_cur.wr_n),
    .fs_n_prv_i   (stb_prv.wr_n),
    .sclk_cur_i   (dat_cur[PIN_SCLK]),
    .sclk_prv_i   (dat_prv[PIN_SCLK]),
    .sdata_i      (dat_cur[PIN_SDAT]),
    .msb_first_i  (dat_cur[PIN_ORD]),
    .right_just_i (dat_cur[PIN_JUST]),
    .vld_o        (ser_vld),
    .word_o       (ser_word)
  );

  // R3: load edge independent of the write path
  assign load_fall = stb_prv.load_n & ~stb_cur.load_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_lat <= MID;
      dac_q  <= MID;
      upd_q  <= 1'b0;
    end else begin
      upd_q <= load_fall;
      if (load_fall) dac_q  <= in_lat;
      if (par_vld)      in_lat <= par_word;
      else if (ser_vld) in_lat <= ser_word;
    end
  end

  assign dac_code_o   = dac_q;
  assign dac_update_o = upd_q;

endmodule

// File: rtl/dac_dual_front_chk.sv
module dac_dual_front_chk #(
  parameter int unsigned WORD_W      = 14,
  parameter int unsigned SYNC_STAGES = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ser_strap_i,
  input logic              sel_n_i,
  input logic              wr_n_i,
  input logic              load_n_i,
  input logic [WORD_W-1:0] in_lat_i,
  input logic [WORD_W-1:0] dac_code_i,
  input logic              upd_i
);

  localparam int unsigned LAG = SYNC_STAGES + 1;

  // R3: the output moves only in an update cycle
  assert_code_moves_on_update_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(dac_code_i) |-> upd_i);

  // R3: an update shows the input latch as it stood one cycle earlier
  assert_update_copies_latch_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |-> (dac_code_i == $past(in_lat_i)));

  // R4: the update pulse never lasts two cycles
  assert_update_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> !upd_i);

  // R10: an update needs the load pin to have been low LAG samples back
  assert_update_needs_load_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |-> !$past(load_n_i, LAG));

  // R2: parallel capture only after the select-and-write window closed
  assert_par_capture_window_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ser_strap_i && !$stable(in_lat_i)) |-> $past(sel_n_i | wr_n_i, LAG));

  // R9: serial capture only after the frame sync went high
  assert_ser_capture_close_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ser_strap_i && !$stable(in_lat_i)) |-> $past(wr_n_i, LAG));

endmodule

bind dac_dual_front dac_dual_front_chk #(
  .WORD_W      (WORD_W),
  .SYNC_STAGES (SYNC_STAGES)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ser_strap_i (ser_strap_i),
  .sel_n_i     (sel_n_i),
  .wr_n_i      (wr_n_i),
  .load_n_i    (load_n_i),
  .in_lat_i    (in_lat),
  .dac_code_i  (dac_code_o),
  .upd_i       (dac_update_o)
);

// File: tb/dac_dual_front_bench.sv
module dac_dual_front_bench;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ser_strap_i = 1'b0;
  logic        sel_n_i = 1'b1;
  logic        wr_n_i = 1'b1;
  logic [13:0] data_i = '0;
  logic        load_n_i = 1'b1;
  logic [13:0] dac_code_o;
  logic        dac_update_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  dac_dual_front u_dac_dual_front (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ser_strap_i  (ser_strap_i),
    .sel_n_i      (sel_n_i),
    .wr_n_i       (wr_n_i),
    .data_i       (data_i),
    .load_n_i     (load_n_i),
    .dac_code_o   (dac_code_o),
    .dac_update_o (dac_update_o)
  );

  task automatic chk(input string tag, input logic [13:0] act, input logic [13:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  typedef struct {
    logic ld, wr, sel;
    logic [13:0] d;
  } smp_t;

  smp_t        hist[4];
  logic [13:0] m_in, m_dac;
  logic        m_upd;
  bit          rxq[$];

  function automatic logic [13:0] assemble(input bit q[$], input logic msb, input logic rj);
    logic [13:0] w = '0;
    int st = rj ? q.size() - 14 : 0;
    for (int i = 0; i < 14; i++) begin
      if (msb) w[13-i] = q[st+i];
      else     w[i]    = q[st+i];
    end
    return w;
  endfunction

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      for (int i = 0; i < 4; i++) hist[i] = '{ld: 1'b1, wr: 1'b1, sel: 1'b1, d: 14'h0};
      m_in = 14'h2000; m_dac = 14'h2000; m_upd = 1'b0; rxq.delete();
    end else begin
      smp_t c, p;
      for (int i = 3; i > 0; i--) hist[i] = hist[i-1];
      hist[0] = '{ld: load_n_i, wr: wr_n_i, sel: sel_n_i, d: data_i};
      c = hist[2]; p = hist[3];
      m_upd = p.ld && !c.ld;
      if (m_upd) m_dac = m_in;
      if (!ser_strap_i) begin
        if (!p.sel && !p.wr && !(!c.sel && !c.wr)) m_in = c.d;
      end else begin
        if (p.wr && !c.wr) rxq.delete();
        else if (!c.wr && p.d[12] && !c.d[12]) begin
          if (rxq.size() < 16) rxq.push_back(c.d[13]);
        end else if (c.wr && !p.wr && rxq.size() >= 14) m_in = assemble(rxq, c.d[11], c.d[10]);
      end
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      chk("R10 model dac_code", dac_code_o, m_dac);
      chk("R4 model update", {13'h0, dac_update_o}, {13'h0, m_upd});
    end
  end

  // ---------------- stimulus helpers ----------------
  logic [13:0] exp_dac;

  task automatic do_reset(input logic strap);
    @(negedge clk_i);
    rst_ni = 1'b0; sel_n_i = 1'b1; wr_n_i = 1'b1; load_n_i = 1'b1; data_i = '0;
    repeat (3) @(negedge clk_i);
    ser_strap_i = strap;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    exp_dac = 14'h2000;
    repeat (2) @(negedge clk_i);
    chk("R1 reset code", dac_code_o, 14'h2000);
    chk("R1 reset update", {13'h0, dac_update_o}, 14'h0);
  endtask

  task automatic do_load(input logic [13:0] nxt, input string tag);
    @(negedge clk_i); load_n_i = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    chk("R10 no change after edge 2", dac_code_o, exp_dac);
    chk("R10 no update after edge 2", {13'h0, dac_update_o}, 14'h0);
    @(negedge clk_i);
    chk(tag, dac_code_o, nxt);
    chk("R4 update pulse", {13'h0, dac_update_o}, 14'h1);
    @(negedge clk_i);
    chk("R4 update one cycle", {13'h0, dac_update_o}, 14'h0);
    load_n_i = 1'b1;
    repeat (3) @(negedge clk_i);
    exp_dac = nxt;
  endtask

  task automatic par_write(input logic [13:0] w, input logic use_sel, input logic use_wr);
    @(negedge clk_i); data_i = w; sel_n_i = !use_sel;
    @(negedge clk_i); wr_n_i = !use_wr;
    repeat (3) @(negedge clk_i);
    wr_n_i = 1'b1;
    @(negedge clk_i); sel_n_i = 1'b1;
    repeat (3) @(negedge clk_i);
  endtask

  bit fb[$];

  // Frame built from a word; junk bits are 1
  task automatic build(input logic [13:0] w, input logic msb, input int pre, input int post, input int keep);
    fb.delete();
    for (int i = 0; i < pre; i++) fb.push_back(1'b1);
    for (int i = 0; i < 14; i++) fb.push_back(msb ? w[13-i] : w[i]);
    for (int i = 0; i < post; i++) fb.push_back(1'b1);
    while (fb.size() > keep) void'(fb.pop_back());
  endtask

  task automatic send_frame(input logic msb, input logic rj, input logic open_fs);
    @(negedge clk_i); data_i = '0; data_i[11] = msb; data_i[10] = rj;
    repeat (2) @(negedge clk_i);
    wr_n_i = !open_fs;
    repeat (4) @(negedge clk_i);
    foreach (fb[i]) begin
      data_i[13] = fb[i]; data_i[12] = 1'b1;
      repeat (8) @(negedge clk_i);
      data_i[12] = 1'b0;
      repeat (8) @(negedge clk_i);
    end
    repeat (4) @(negedge clk_i);
    wr_n_i = 1'b1;
    repeat (6) @(negedge clk_i);
  endtask

  // ---------------- test sequence ----------------
  initial begin
    // Parallel mode
    do_reset(1'b0);
    do_load(14'h2000, "R1 input latch reset to mid-scale");
    par_write(14'h1234, 1'b1, 1'b1);
    chk("R3 write alone keeps output", dac_code_o, 14'h2000);
    do_load(14'h1234, "R2 parallel capture");
    par_write(14'h0ABC, 1'b0, 1'b1);
    do_load(14'h1234, "R2 write without select ignored");
    par_write(14'h3FFF, 1'b1, 1'b0);
    do_load(14'h1234, "R2 select without write ignored");
    par_write(14'h3FFF, 1'b1, 1'b1);
    par_write(14'h0001, 1'b1, 1'b1);
    do_load(14'h0001, "R3 latest write transferred");
    do_load(14'h0001, "R4 repeat load same value");

    // Serial mode
    do_reset(1'b1);
    build(14'h2A5C, 1'b1, 2, 0, 99); send_frame(1'b1, 1'b1, 1'b1);
    chk("R3 frame alone keeps output", dac_code_o, 14'h2000);
    do_load(14'h2A5C, "R7 MSB first right justified");
    build(14'h1357, 1'b0, 2, 0, 99); send_frame(1'b0, 1'b1, 1'b1);
    do_load(14'h1357, "R7 LSB first right justified");
    build(14'h3C01, 1'b1, 0, 2, 99); send_frame(1'b1, 1'b0, 1'b1);
    do_load(14'h3C01, "R8 left justified 16 bits");
    build(14'h0F0F, 1'b1, 0, 0, 99); send_frame(1'b1, 1'b1, 1'b1);
    do_load(14'h0F0F, "R8 right justified 14 bits");
    build(14'h1248, 1'b0, 0, 1, 99); send_frame(1'b0, 1'b0, 1'b1);
    do_load(14'h1248, "R8 left justified 15 bits LSB first");
    build(14'h3333, 1'b1, 2, 2, 99); send_frame(1'b1, 1'b1, 1'b1);
    do_load(14'h3333, "R8 bits past 16 dropped");
    build(14'h0555, 1'b1, 0, 0, 12); send_frame(1'b1, 1'b1, 1'b1);
    do_load(14'h3333, "R9 short frame ignored");
    build(14'h0000, 1'b1, 0, 0, 99); send_frame(1'b1, 1'b1, 1'b0);
    do_load(14'h3333, "R6 clocks with sync high ignored");
    par_write(14'h0101, 1'b1, 1'b1);
    do_load(14'h3333, "R5 parallel strobe ignored in serial mode");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule